// File: doc/BRIEF.md
# Effective Address Generator with Penalty Flag

This block resolves the operand address of an 8-bit accumulator processor with a 16-bit address space. The sequencer raises `start` for one cycle and presents the addressing mode, the program counter, the two operand bytes, the two index registers and two instruction attributes. The block returns the effective address, the instruction length in bytes, and a flag that requests one extra cycle when an indexed address carries out of its low byte.

Modes that need no memory data finish in the cycle after `start`. The two pointer-based modes and the two jump-indirect forms read a 16-bit pointer, low byte first, through a synchronous read port, one read per cycle. Read data arrives in the cycle after the request. The block copies the processor's wraparound quirks. A pointer kept in page zero wraps inside page zero. The indirect jump with the quirk fetches its high byte from offset 0x00 of the same page. `start` is ignored while the block is busy.

Top module: `eff_addr_gen`

## Requirements
- R1: Zero page (mode 3) gives address 0x00:opnd_lo. Zero page indexed by X (mode 4) or by Y (mode 5) adds the index to opnd_lo modulo 256, so the high address byte is always 0x00.
- R2: Absolute indexed by X (mode 7) or by Y (mode 8) adds the index to {opnd_hi, opnd_lo} modulo 65536. The raw penalty is 1 exactly when the low-byte sum carries.
- R3: Indexed-indirect (mode 9) forms pointer p = (opnd_lo + X) mod 256. It reads the low target byte at 0x00:p and the high byte at 0x00:(p+1 mod 256), so p = 0xFF takes its high byte from 0x0000.
- R4: Indirect-indexed (mode 10) reads a pointer at 0x00:opnd_lo and 0x00:(opnd_lo+1 mod 256). It adds Y to the pointer modulo 65536 and raises the raw penalty on a low-byte carry.
- R5: Quirked jump-indirect (mode 13) reads the low byte at {opnd_hi, opnd_lo} and the high byte at {opnd_hi, opnd_lo+1 mod 256}. This is the same page, even when opnd_lo is 0xFF.
- R6: Relative (mode 11) gives pc plus sign-extended opnd_lo, modulo 65536.
- R7: Immediate (mode 2) gives pc+1 modulo 65536. Absolute (mode 6) gives {opnd_hi, opnd_lo}. Accumulator (mode 0) and implied (mode 1) give 0x0000 and no penalty.
- R8: inst_len is 1 for modes 0 and 1, and 3 for modes 6, 7, 8, 12 and 13. It is 2 for modes 2, 3, 4, 5, 9, 10 and 11.
- R9: The reported penalty is forced to 0 when store_acc or seven_cyc was high with `start`.
- R10: For modes 0 through 8 and mode 11, done pulses one cycle after `start`, with no memory read. Modes 9, 10, 12 and 13 issue reads in the first and second cycles after `start`, low byte first, and pulse done four cycles after `start`.
- R11: A `start` raised while busy is high is ignored. It produces no done pulse and does not disturb the result in flight.
- R12: During and after reset, done, busy and mem_rd_en are 0.
- R13: Plain jump-indirect (mode 12) reads the low byte at {opnd_hi, opnd_lo} and the high byte at {opnd_hi, opnd_lo} + 1 modulo 65536, crossing into the next page when needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving one instruction's address |
| mode | input | 4 | Addressing mode code (0..13) |
| pc | input | 16 | Program counter value used for immediate and relative |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| x_idx | input | 8 | X index register |
| y_idx | input | 8 | Y index register |
| store_acc | input | 1 | Instruction is an accumulator store; suppresses penalty |
| seven_cyc | input | 1 | Instruction's base cycle count is 7; suppresses penalty |
| busy | output | 1 | A pointer fetch is in progress |
| done | output | 1 | One-cycle pulse: result outputs valid |
| eff_addr | output | 16 | Effective address |
| penalty | output | 1 | Extra cycle for page crossing |
| inst_len | output | 2 | Instruction length in bytes |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after mem_rd_en |

## Verification
Direct modes produce their result exactly one cycle after `start`. Pointer modes produce theirs four cycles after it. The driver stamps each expected item with the cycle count at which it raised `start`. The monitor samples on the falling edge and compares the measured distance against 1 or 4. It also treats any done pulse with an empty queue as a failure, which is how an ignored `start` during a busy fetch is caught. The memory model answers every read with a byte computed from its address. A wrong high-byte address for a wrapped pointer therefore shows up as a wrong effective address.

// File: rtl/eff_addr_pkg.sv
// Package: shared addressing-mode codes and per-mode decode helpers.
// Assumes the mode field is 4 bits wide; codes 14 and 15 are unused.
package eff_addr_pkg;

    typedef enum logic [3:0] {
        AM_ACC  = 4'd0,
        AM_IMPL = 4'd1,
        AM_IMM  = 4'd2,
        AM_ZP   = 4'd3,
        AM_ZPX  = 4'd4,
        AM_ZPY  = 4'd5,
        AM_ABS  = 4'd6,
        AM_ABSX = 4'd7,
        AM_ABSY = 4'd8,
        AM_XIND = 4'd9,
        AM_INDY = 4'd10,
        AM_REL  = 4'd11,
        AM_IND  = 4'd12,
        AM_JIND = 4'd13
    } am_e;

    // Instruction length in bytes for a mode.
    function automatic logic [1:0] am_length(am_e m);
        case (m)
            AM_ACC, AM_IMPL:                         am_length = 2'd1;
            AM_ABS, AM_ABSX, AM_ABSY, AM_IND, AM_JIND: am_length = 2'd3;
            default:                                 am_length = 2'd2;
        endcase
    endfunction

    // True for modes that must fetch a two-byte pointer from memory.
    function automatic logic am_fetches(am_e m);
        am_fetches = (m == AM_XIND) || (m == AM_INDY) ||
                     (m == AM_IND)  || (m == AM_JIND);
    endfunction

endpackage

// File: rtl/ea_direct.sv
// Module: ea_direct
// Resolves the addresses that need no memory data, from live inputs.
// Assumes AW == 2*DW (one high byte, one low byte).
module ea_direct
    import eff_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  am_e           mode,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] op_lo,
    input  logic [DW-1:0] op_hi,
    input  logic [DW-1:0] xr,
    input  logic [DW-1:0] yr,
    output logic [AW-1:0] addr,
    output logic          lo_carry
);
    localparam int HW = AW - DW;

    logic [DW-1:0] idx;
    logic [DW-1:0] zp_sum;
    logic [AW-1:0] abs_sum;

    // Pick the index register for the indexed forms.
    always_comb idx = (mode == AM_ZPY || mode == AM_ABSY) ? yr : xr;

    // Page-zero sum keeps only the low byte; absolute sum spans the full address.
    always_comb begin
        zp_sum  = op_lo + idx;
        abs_sum = {op_hi, op_lo} + {{HW{1'b0}}, idx};
    end

    // Per-mode address selection and low-byte carry detection.
    always_comb begin
        addr     = '0;
        lo_carry = 1'b0;
        case (mode)
            AM_IMM:  addr = pc + {{(AW-1){1'b0}}, 1'b1};
            AM_ZP:   addr = {{HW{1'b0}}, op_lo};
            AM_ZPX,
            AM_ZPY:  addr = {{HW{1'b0}}, zp_sum};
            AM_ABS:  addr = {op_hi, op_lo};
            AM_ABSX,
            AM_ABSY: begin
                addr     = abs_sum;
                lo_carry = abs_sum[DW-1:0] < idx;
            end
            AM_REL:  addr = pc + {{HW{op_lo[DW-1]}}, op_lo};
            default: addr = '0;
        endcase
    end
endmodule

// File: rtl/ea_ptr.sv
// Module: ea_ptr
// Forms the two byte addresses of a pointer fetch, including the
// page-zero wrap and the same-page quirk of the indirect jump.
// Assumes inputs are held stable for the whole fetch.
module ea_ptr
    import eff_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  am_e           mode,
    input  logic [DW-1:0] op_lo,
    input  logic [DW-1:0] op_hi,
    input  logic [DW-1:0] xr,
    output logic [AW-1:0] lo_addr,
    output logic [AW-1:0] hi_addr
);
    localparam int HW = AW - DW;
    localparam logic [DW-1:0] ONE_B = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] zp_ptr;
    logic [AW-1:0] full_ptr;

    // Page-zero pointer: pre-indexed by X for indexed-indirect, plain otherwise.
    always_comb begin
        zp_ptr   = (mode == AM_XIND) ? op_lo + xr : op_lo;
        full_ptr = {op_hi, op_lo};
    end

    // Low byte at the pointer; high byte at the mode's notion of "next".
    always_comb begin
        case (mode)
            AM_IND: begin
                lo_addr = full_ptr;
                hi_addr = full_ptr + {{(AW-1){1'b0}}, 1'b1};
            end
            AM_JIND: begin
                lo_addr = full_ptr;
                hi_addr = {op_hi, op_lo + ONE_B};
            end
            default: begin
                lo_addr = {{HW{1'b0}}, zp_ptr};
                hi_addr = {{HW{1'b0}}, zp_ptr + ONE_B};
            end
        endcase
    end
endmodule

// File: rtl/ea_final.sv
// Module: ea_final
// Combines the fetched pointer bytes into the final address, adding Y
// for indirect-indexed and reporting its low-byte carry.
// Assumes data bytes are valid in the cycle they are consumed.
module ea_final
    import eff_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  am_e           mode,
    input  logic [DW-1:0] d_lo,
    input  logic [DW-1:0] d_hi,
    input  logic [DW-1:0] yr,
    output logic [AW-1:0] addr,
    output logic          lo_carry
);
    localparam int HW = AW - DW;

    logic [AW-1:0] base;
    logic [AW-1:0] post;

    // Assemble pointer and its Y-indexed form.
    always_comb begin
        base = {d_hi, d_lo};
        post = base + {{HW{1'b0}}, yr};
    end

    // Select by mode; only indirect-indexed carries a penalty.
    always_comb begin
        if (mode == AM_INDY) begin
            addr     = post;
            lo_carry = post[DW-1:0] < yr;
        end else begin
            addr     = base;
            lo_carry = 1'b0;
        end
    end
endmodule

// File: rtl/eff_addr_gen.sv
// Module: eff_addr_gen (top)
// Start/done address resolver. Direct modes finish one cycle after start;
// pointer modes fetch two bytes (low first) over a synchronous read port
// and finish four cycles after start. Start is ignored while busy.
// Assumes mem_rd_data is valid one cycle after mem_rd_en.
module eff_addr_gen
    import eff_addr_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] opnd_lo,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] x_idx,
    input  logic [DW-1:0] y_idx,
    input  logic          store_acc,
    input  logic          seven_cyc,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] eff_addr,
    output logic          penalty,
    output logic [1:0]    inst_len,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rd_data
);
    typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_FIN} st_e;

    st_e           state;
    am_e           mode_in, mode_q;
    logic [DW-1:0] lo_q, hi_q, x_q, y_q, dlo_q;
    logic          mask_q;
    logic [AW-1:0] dir_addr, plo_addr, phi_addr, fin_addr;
    logic          dir_carry, fin_carry;

    // Interpret the raw mode code.
    always_comb mode_in = am_e'(mode);

    ea_direct #(.AW(AW), .DW(DW)) u_direct (
        .mode(mode_in), .pc(pc), .op_lo(opnd_lo), .op_hi(opnd_hi),
        .xr(x_idx), .yr(y_idx), .addr(dir_addr), .lo_carry(dir_carry)
    );

    ea_ptr #(.AW(AW), .DW(DW)) u_ptr (
        .mode(mode_q), .op_lo(lo_q), .op_hi(hi_q), .xr(x_q),
        .lo_addr(plo_addr), .hi_addr(phi_addr)
    );

    ea_final #(.AW(AW), .DW(DW)) u_final (
        .mode(mode_q), .d_lo(dlo_q), .d_hi(mem_rd_data), .yr(y_q),
        .addr(fin_addr), .lo_carry(fin_carry)
    );

    // Sequencer: accept, fetch pointer bytes, register results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            mode_q   <= AM_ACC;
            lo_q     <= '0;
            hi_q     <= '0;
            x_q      <= '0;
            y_q      <= '0;
            dlo_q    <= '0;
            mask_q   <= 1'b0;
            done     <= 1'b0;
            eff_addr <= '0;
            penalty  <= 1'b0;
            inst_len <= 2'd0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    mode_q <= mode_in;
                    lo_q   <= opnd_lo;
                    hi_q   <= opnd_hi;
                    x_q    <= x_idx;
                    y_q    <= y_idx;
                    mask_q <= store_acc | seven_cyc;
                    if (am_fetches(mode_in)) begin
                        state <= ST_LO;
                    end else begin
                        done     <= 1'b1;
                        eff_addr <= dir_addr;
                        penalty  <= dir_carry & ~(store_acc | seven_cyc);
                        inst_len <= am_length(mode_in);
                    end
                end
                ST_LO: state <= ST_HI;
                ST_HI: begin
                    dlo_q <= mem_rd_data;
                    state <= ST_FIN;
                end
                ST_FIN: begin
                    done     <= 1'b1;
                    eff_addr <= fin_addr;
                    penalty  <= fin_carry & ~mask_q;
                    inst_len <= am_length(mode_q);
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read port and busy indication follow the fetch states.
    always_comb begin
        busy      = (state != ST_IDLE);
        mem_rd_en = (state == ST_LO) || (state == ST_HI);
        case (state)
            ST_LO:   mem_addr = plo_addr;
            ST_HI:   mem_addr = phi_addr;
            default: mem_addr = '0;
        endcase
    end

    // ---------------- assertions ----------------
    assert_direct_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !am_fetches(mode_in)) |=> (done && !mem_rd_en));

    assert_fetch_reads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_rd_en ##1 mem_rd_en ##1 !mem_rd_en ##1 done));

    assert_zp_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == AM_ZP || mode_q == AM_ZPX || mode_q == AM_ZPY))
        |-> (eff_addr[AW-1:DW] == '0));

    assert_xind_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && (mode_q == AM_XIND || mode_q == AM_INDY))
        |-> (mem_addr[AW-1:DW] == '0));

    assert_jind_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI && mode_q == AM_JIND)
        |-> (mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW])));

    assert_penalty_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mask_q) |-> !penalty);

    assert_short_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (mode_q == AM_ACC || mode_q == AM_IMPL)) |-> (inst_len == 2'd1));

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_reset_quiet_R12: assert property (@(posedge clk)
        !rst_n |=> (!done && !busy && !mem_rd_en));
endmodule

// File: tb/eff_addr_gen_bench.sv
// Scoreboard bench: driver pushes expected results; monitor compares on done.
module eff_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [15:0] pc = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, x_idx = '0, y_idx = '0;
    logic        store_acc = 1'b0, seven_cyc = 1'b0;
    logic        busy, done, penalty, mem_rd_en;
    logic [15:0] eff_addr, mem_addr;
    logic [1:0]  inst_len;
    logic [7:0]  mem_rd_data = '0;

    int checks = 0, fails = 0, cyc = 0, dones = 0, pushes = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] a;
        logic        p;
        logic [1:0]  l;
        int          lat;
        int          sc;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    eff_addr_gen u_eff_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc(pc),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .x_idx(x_idx), .y_idx(y_idx),
        .store_acc(store_acc), .seven_cyc(seven_cyc), .busy(busy), .done(done),
        .eff_addr(eff_addr), .penalty(penalty), .inst_len(inst_len),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    // Memory model: each byte is a fixed function of its address.
    function automatic logic [7:0] fmem(logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hA5;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= fmem(mem_addr);

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Build the expected result from the requirements and issue one start.
    task automatic run(string tag, logic [3:0] m, logic [15:0] p, logic [7:0] lo,
                       logic [7:0] hi, logic [7:0] x, logic [7:0] y,
                       logic st, logic b7);
        exp_t e;
        logic [7:0] zp;
        logic [15:0] b;
        e.p = 1'b0; e.lat = 1; e.tag = tag; e.a = 16'h0000;
        case (m)
            4'd0, 4'd1: begin e.l = 2'd1; end
            4'd2: begin e.a = p + 16'd1; e.l = 2'd2; end
            4'd3: begin e.a = {8'h00, lo}; e.l = 2'd2; end
            4'd4: begin zp = lo + x; e.a = {8'h00, zp}; e.l = 2'd2; end
            4'd5: begin zp = lo + y; e.a = {8'h00, zp}; e.l = 2'd2; end
            4'd6: begin e.a = {hi, lo}; e.l = 2'd3; end
            4'd7: begin e.a = {hi, lo} + {8'h00, x}; e.p = ({1'b0, lo} + {1'b0, x}) > 9'd255; e.l = 2'd3; end
            4'd8: begin e.a = {hi, lo} + {8'h00, y}; e.p = ({1'b0, lo} + {1'b0, y}) > 9'd255; e.l = 2'd3; end
            4'd9: begin
                zp = lo + x;
                e.a = {fmem({8'h00, zp + 8'd1}), fmem({8'h00, zp})};
                e.l = 2'd2; e.lat = 4;
            end
            4'd10: begin
                b = {fmem({8'h00, lo + 8'd1}), fmem({8'h00, lo})};
                e.a = b + {8'h00, y};
                e.p = ({1'b0, b[7:0]} + {1'b0, y}) > 9'd255;
                e.l = 2'd2; e.lat = 4;
            end
            4'd11: begin e.a = p + {{8{lo[7]}}, lo}; e.l = 2'd2; end
            4'd12: begin
                b = {hi, lo};
                e.a = {fmem(b + 16'd1), fmem(b)}; e.l = 2'd3; e.lat = 4;
            end
            default: begin
                e.a = {fmem({hi, lo + 8'd1}), fmem({hi, lo})}; e.l = 2'd3; e.lat = 4;
            end
        endcase
        if (st || b7) e.p = 1'b0;
        @(negedge clk);
        mode = m; pc = p; opnd_lo = lo; opnd_hi = hi; x_idx = x; y_idx = y;
        store_acc = st; seven_cyc = b7; start = 1'b1;
        e.sc = cyc;
        q.push_back(e); pushes++;
        @(negedge clk);
        start = 1'b0;
        while (busy || q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each done against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected done: actual addr %0h expected no done", eff_addr);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "eff_addr", 32'(eff_addr), 32'(e.a));
                chk(e.tag, "penalty", 32'(penalty), 32'(e.p));
                chk("R8", "inst_len", 32'(inst_len), 32'(e.l));
                chk("R10", "latency", 32'(cyc - e.sc), 32'(e.lat));
            end
        end
    end

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "done in reset", 32'(done), 0);
        chk("R12", "busy in reset", 32'(busy), 0);
        chk("R12", "rd_en in reset", 32'(mem_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12", "done after reset", 32'(done), 0);

        run("R1", 4'd3, 16'h0200, 8'h7C, 8'h11, 8'h00, 8'h00, 0, 0);
        run("R1", 4'd4, 16'h0200, 8'hF0, 8'h11, 8'h20, 8'h00, 0, 0);
        run("R1", 4'd5, 16'h0200, 8'h10, 8'h22, 8'h00, 8'h05, 0, 0);
        run("R2", 4'd7, 16'h0000, 8'hF0, 8'h12, 8'h20, 8'h00, 0, 0);
        run("R2", 4'd8, 16'h0000, 8'h34, 8'h12, 8'h00, 8'h01, 0, 0);
        run("R2", 4'd7, 16'h0000, 8'hFF, 8'hFF, 8'h01, 8'h00, 0, 0);
        run("R3", 4'd9, 16'h0000, 8'hFE, 8'h00, 8'h01, 8'h00, 0, 0);
        run("R3", 4'd9, 16'h0000, 8'h30, 8'h00, 8'h10, 8'h00, 0, 0);
        run("R4", 4'd10, 16'h0000, 8'hFF, 8'h00, 8'h00, 8'h80, 0, 0);
        run("R4", 4'd10, 16'h0000, 8'h20, 8'h00, 8'h00, 8'hF0, 0, 0);
        run("R5", 4'd13, 16'h0000, 8'hFF, 8'h12, 8'h00, 8'h00, 0, 0);
        run("R13", 4'd12, 16'h0000, 8'hFF, 8'h12, 8'h00, 8'h00, 0, 0);
        run("R6", 4'd11, 16'h1000, 8'h80, 8'h00, 8'h00, 8'h00, 0, 0);
        run("R6", 4'd11, 16'hFFF0, 8'h20, 8'h00, 8'h00, 8'h00, 0, 0);
        run("R7", 4'd2, 16'hFFFF, 8'h00, 8'h00, 8'h00, 8'h00, 0, 0);
        run("R7", 4'd6, 16'h0000, 8'hCD, 8'hAB, 8'h00, 8'h00, 0, 0);
        run("R7", 4'd0, 16'h4321, 8'h55, 8'h66, 8'h77, 8'h88, 0, 0);
        run("R8", 4'd1, 16'h4321, 8'h55, 8'h66, 8'h77, 8'h88, 0, 0);
        run("R9", 4'd7, 16'h0000, 8'hF0, 8'h12, 8'h20, 8'h00, 1, 0);
        run("R9", 4'd10, 16'h0000, 8'hFF, 8'h00, 8'h00, 8'h80, 0, 1);

        // R11: a second start while the fetch is in flight must be ignored.
        begin
            exp_t e;
            logic [15:0] b;
            b = {fmem(16'h0041), fmem(16'h0040)} + 16'h00C0;
            e.a = b; e.p = ({1'b0, b[7:0]} < 9'h0C0) ? 1'b0 : 1'b0;
            e.p = ({1'b0, fmem(16'h0040)} + 9'h0C0) > 9'd255;
            e.l = 2'd2; e.lat = 4; e.tag = "R11";
            @(negedge clk);
            mode = 4'd10; opnd_lo = 8'h40; y_idx = 8'hC0; store_acc = 0; seven_cyc = 0;
            start = 1'b1; e.sc = cyc; q.push_back(e); pushes++;
            @(negedge clk);
            mode = 4'd3; opnd_lo = 8'h99; y_idx = 8'h00;
            @(negedge clk);
            start = 1'b0;
            while (busy || q.size() != 0) @(negedge clk);
            repeat (3) @(negedge clk);
            chk("R11", "done count", 32'(dones), 32'(pushes));
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule